// File: doc/BRIEF.md
# Ethernet Pause Frame Detector

This block sits on the receive side of an Ethernet MAC and watches the incoming byte stream for flow-control frames. It recognises two formats. One is the standard pause frame, which carries a single pause time. The other is the priority-based pause frame, which carries a priority enable vector and one pause time per priority. To qualify, a frame must have an accepted destination address, the flow-control EtherType and a known opcode. The block captures the pause fields as the bytes go past. When the frame ends, it reports at most one validated pause event.

An event is committed only when four conditions hold: the end-of-frame status reports a 64-byte frame with no CRC error, the pause fields were fully received, flow control is enabled and the link is full duplex. The event lasts one cycle. Timers, transmit blocking and frame forwarding belong to other blocks that consume this pulse.

Top module: `pause_det`

## Requirements
- R1: A frame whose first six bytes equal 01 80 C2 00 00 01 (byte 0 first) passes the destination-address test.
- R2: A frame whose first six bytes equal `station_addr_i`, with bits 47:40 as byte 0, passes the destination-address test only while `ucast_en_i` is 1. With `ucast_en_i` at 0, such a frame produces no event.
- R3: Bytes 12 and 13 must be 88h and 08h. Any other value produces no event.
- R4: Opcode bytes 14–15 equal to 00h 01h give a standard event. In that event, `is_pfc_o`=0, `pause_time_o`={byte16,byte17}, `pev_o`=0 and every `pfc_time_o` entry is 0.
- R5: Opcode bytes 14–15 equal to 01h 01h give a priority event only while `pfc_en_i` is 1. In that event, `is_pfc_o`=1, `pev_o`=byte17, `pause_time_o`=0 and `pfc_time_o[n]`={byte 18+2n, byte 19+2n}. Any other opcode, or this opcode with `pfc_en_i` at 0, gives no event.
- R6: An event is committed only if, on the last beat, `eof_len_i` equals 64 and `eof_crc_err_i` is 0.
- R7: No event is produced while `rx_fc_en_i` is 0.
- R8: No event is produced while `full_duplex_i` is 0.
- R9: `pause_valid_o` is high for exactly one cycle, in the cycle after the clock edge that takes the last beat. All data outputs are 0 whenever `pause_valid_o` is 0, including after reset.
- R10: No event is produced if the last beat falls before byte 17 for a standard frame, or before byte 33 for a priority frame.
- R11: Cycles with `rx_valid_i` at 0 are ignored. A beat with `rx_sof_i` set restarts byte indexing and discards any unfinished frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_valid_i | input | 1 | Byte beat valid |
| rx_sof_i | input | 1 | Beat is byte 0 of a frame |
| rx_eof_i | input | 1 | Beat is the last byte of a frame |
| rx_data_i | input | 8 | Received byte |
| eof_len_i | input | 16 | Frame byte count, valid on the last beat |
| eof_crc_err_i | input | 1 | CRC error flag, valid on the last beat |
| station_addr_i | input | 48 | Station unicast address |
| rx_fc_en_i | input | 1 | Receive flow-control enable |
| ucast_en_i | input | 1 | Accept pause frames sent to the station address |
| pfc_en_i | input | 1 | Accept priority pause frames |
| full_duplex_i | input | 1 | Link is full duplex |
| pause_valid_o | output | 1 | One-cycle validated pause event |
| is_pfc_o | output | 1 | Event is a priority pause |
| pause_time_o | output | 16 | Standard pause time |
| pev_o | output | 8 | Priority enable vector |
| pfc_time_o | output | 8x16 | Per-priority pause times, entry n for priority n |

## Verification
Internal state in this block shows up only through the event that follows a frame's last beat, so a fault becomes visible one cycle after that beat or not at all. A stuck or misaligned byte index either loses events, when a good frame fails the header test, or moves field bytes into the wrong outputs. Directed frames with distinct byte values in every field expose both symptoms. A match flag that is not reset at a start beat is exposed by a good frame sent right after a bad or unfinished one. A wrong commit condition is exposed by frames that differ from a good one in exactly one qualifier.

// File: rtl/pause_det_pkg.sv
package pause_det_pkg;
  localparam logic [47:0] CTRL_MCAST_DA = 48'h0180C2000001;
  localparam logic [15:0] FC_ETYPE      = 16'h8808;
  localparam logic [15:0] OPC_STD       = 16'h0001;
  localparam logic [15:0] OPC_PRIO      = 16'h0101;

  localparam int unsigned DA_BYTES  = 6;
  localparam int unsigned POS_TYPE  = 12;
  localparam int unsigned POS_OPC   = 14;
  localparam int unsigned POS_F16   = 16;
  localparam int unsigned POS_TIMES = 18;

  typedef struct packed {
    logic mc_ok;
    logic uc_ok;
    logic type_ok;
    logic op_std;
    logic op_prio;
  } hdr_flags_t;

  function automatic logic [7:0] addr_byte(input logic [47:0] addr, input int unsigned k);
    logic [7:0] b;
    b = 8'h00;
    for (int unsigned j = 0; j < DA_BYTES; j++) begin
      if (j == k) b = addr[8*(DA_BYTES-1-j) +: 8];
    end
    return b;
  endfunction
endpackage

// File: rtl/pause_byte_idx.sv
module pause_byte_idx #(
  parameter int unsigned IDX_W = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             beat_i,
  input  logic             sof_i,
  output logic [IDX_W-1:0] cur_idx_o
);
  logic [IDX_W-1:0] idx_q;

  assign cur_idx_o = sof_i ? '0 : idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q <= '0;
    end else if (beat_i) begin
      if (cur_idx_o != '1) idx_q <= cur_idx_o + 1'b1;
      else                 idx_q <= cur_idx_o;
    end
  end

  AST_IDX_ADVANCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (beat_i && sof_i) |=> (idx_q == IDX_W'(1))) else $error("index restart"); // R11
endmodule

// File: rtl/pause_hdr_match.sv
module pause_hdr_match
  import pause_det_pkg::*;
#(
  parameter int unsigned IDX_W = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             beat_i,
  input  logic             sof_i,
  input  logic [IDX_W-1:0] cur_idx_i,
  input  logic [7:0]       data_i,
  input  logic [47:0]      station_addr_i,
  output hdr_flags_t       flags_o
);
  hdr_flags_t flags_q, base, hit;
  int unsigned k;

  always_comb begin
    k    = int'(cur_idx_i);
    base = sof_i ? '1 : flags_q;
    hit  = '1;
    if (k < DA_BYTES) begin
      hit.mc_ok = (data_i == addr_byte(CTRL_MCAST_DA, k));
      hit.uc_ok = (data_i == addr_byte(station_addr_i, k));
    end
    if (k == POS_TYPE)   hit.type_ok = (data_i == FC_ETYPE[15:8]);
    if (k == POS_TYPE+1) hit.type_ok = (data_i == FC_ETYPE[7:0]);
    if (k == POS_OPC) begin
      hit.op_std  = (data_i == OPC_STD[15:8]);
      hit.op_prio = (data_i == OPC_PRIO[15:8]);
    end
    if (k == POS_OPC+1) begin
      hit.op_std  = (data_i == OPC_STD[7:0]);
      hit.op_prio = (data_i == OPC_PRIO[7:0]);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     flags_q <= '0;
    else if (beat_i) flags_q <= base & hit;
  end

  assign flags_o = flags_q;

  AST_OPC_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(flags_q.op_std && flags_q.op_prio && (cur_idx_i > IDX_W'(POS_OPC+1)))) else $error("two opcodes"); // R5
endmodule

// File: rtl/pause_field_cap.sv
module pause_field_cap
  import pause_det_pkg::*;
#(
  parameter int unsigned IDX_W    = 7,
  parameter int unsigned NUM_PRIO = 8
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         beat_i,
  input  logic [IDX_W-1:0]             cur_idx_i,
  input  logic [7:0]                   data_i,
  output logic [15:0]                  f16_o,
  output logic [NUM_PRIO-1:0][15:0]    times_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      f16_o <= '0;
    end else if (beat_i) begin
      if (cur_idx_i == IDX_W'(POS_F16))   f16_o[15:8] <= data_i;
      if (cur_idx_i == IDX_W'(POS_F16+1)) f16_o[7:0]  <= data_i;
    end
  end

  for (genvar p = 0; p < NUM_PRIO; p++) begin : g_prio
    localparam logic [IDX_W-1:0] HI = IDX_W'(POS_TIMES + 2*p);
    localparam logic [IDX_W-1:0] LO = IDX_W'(POS_TIMES + 2*p + 1);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        times_o[p] <= '0;
      end else if (beat_i) begin
        if (cur_idx_i == HI) times_o[p][15:8] <= data_i;
        if (cur_idx_i == LO) times_o[p][7:0]  <= data_i;
      end
    end
  end
endmodule

// File: rtl/pause_commit.sv
module pause_commit
  import pause_det_pkg::*;
#(
  parameter int unsigned IDX_W     = 7,
  parameter int unsigned NUM_PRIO  = 8,
  parameter int unsigned LEN_W     = 16,
  parameter int unsigned FRAME_LEN = 64
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             beat_i,
  input  logic             eof_i,
  input  logic [IDX_W-1:0] cur_idx_i,
  input  hdr_flags_t       flags_i,
  input  logic [LEN_W-1:0] eof_len_i,
  input  logic             eof_crc_err_i,
  input  logic             rx_fc_en_i,
  input  logic             ucast_en_i,
  input  logic             pfc_en_i,
  input  logic             full_duplex_i,
  output logic             ev_o,
  output logic             ev_prio_o
);
  localparam logic [IDX_W-1:0] STD_LAST  = IDX_W'(POS_F16 + 1);
  localparam logic [IDX_W-1:0] PRIO_LAST = IDX_W'(POS_TIMES + 2*NUM_PRIO - 1);

  logic da_ok, std_ok, prio_ok, status_ok, ctrl_ok, fire;

  always_comb begin
    da_ok     = flags_i.mc_ok || (flags_i.uc_ok && ucast_en_i);
    std_ok    = flags_i.op_std && (cur_idx_i >= STD_LAST);
    prio_ok   = flags_i.op_prio && pfc_en_i && (cur_idx_i >= PRIO_LAST);
    status_ok = (eof_len_i == LEN_W'(FRAME_LEN)) && !eof_crc_err_i;
    ctrl_ok   = rx_fc_en_i && full_duplex_i;
    fire      = beat_i && eof_i && da_ok && flags_i.type_ok && status_ok &&
                ctrl_ok && (std_ok || prio_ok);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ev_o      <= 1'b0;
      ev_prio_o <= 1'b0;
    end else begin
      ev_o      <= fire;
      ev_prio_o <= fire && prio_ok;
    end
  end

  AST_CTRL_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_o |-> $past(rx_fc_en_i && full_duplex_i)) else $error("ctrl gate"); // R7
  AST_STATUS_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_o |-> $past(eof_len_i == LEN_W'(FRAME_LEN) && !eof_crc_err_i)) else $error("status gate"); // R6
  AST_PRIO_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_prio_o |-> $past(pfc_en_i)) else $error("prio enable"); // R5
  AST_ONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_o |=> !ev_o) else $error("pulse width"); // R9
  AST_AFTER_EOF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_o |-> $past(beat_i && eof_i)) else $error("no eof"); // R9
endmodule

// File: rtl/pause_det.sv
module pause_det
  import pause_det_pkg::*;
#(
  parameter int unsigned NUM_PRIO  = 8,
  parameter int unsigned IDX_W     = 7,
  parameter int unsigned LEN_W     = 16,
  parameter int unsigned FRAME_LEN = 64
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       rx_valid_i,
  input  logic                       rx_sof_i,
  input  logic                       rx_eof_i,
  input  logic [7:0]                 rx_data_i,
  input  logic [LEN_W-1:0]           eof_len_i,
  input  logic                       eof_crc_err_i,
  input  logic [47:0]                station_addr_i,
  input  logic                       rx_fc_en_i,
  input  logic                       ucast_en_i,
  input  logic                       pfc_en_i,
  input  logic                       full_duplex_i,
  output logic                       pause_valid_o,
  output logic                       is_pfc_o,
  output logic [15:0]                pause_time_o,
  output logic [7:0]                 pev_o,
  output logic [NUM_PRIO-1:0][15:0]  pfc_time_o
);
  logic [IDX_W-1:0]          cur_idx;
  hdr_flags_t                flags;
  logic [15:0]               f16;
  logic [NUM_PRIO-1:0][15:0] times;
  logic                      ev, ev_prio;

  pause_byte_idx #(.IDX_W(IDX_W)) u_idx (
    .clk_i, .rst_ni, .beat_i(rx_valid_i), .sof_i(rx_sof_i), .cur_idx_o(cur_idx)
  );

  pause_hdr_match #(.IDX_W(IDX_W)) u_hdr (
    .clk_i, .rst_ni, .beat_i(rx_valid_i), .sof_i(rx_sof_i), .cur_idx_i(cur_idx),
    .data_i(rx_data_i), .station_addr_i, .flags_o(flags)
  );

  pause_field_cap #(.IDX_W(IDX_W), .NUM_PRIO(NUM_PRIO)) u_cap (
    .clk_i, .rst_ni, .beat_i(rx_valid_i), .cur_idx_i(cur_idx), .data_i(rx_data_i),
    .f16_o(f16), .times_o(times)
  );

  pause_commit #(.IDX_W(IDX_W), .NUM_PRIO(NUM_PRIO), .LEN_W(LEN_W), .FRAME_LEN(FRAME_LEN)) u_commit (
    .clk_i, .rst_ni, .beat_i(rx_valid_i), .eof_i(rx_eof_i), .cur_idx_i(cur_idx),
    .flags_i(flags), .eof_len_i, .eof_crc_err_i, .rx_fc_en_i, .ucast_en_i,
    .pfc_en_i, .full_duplex_i, .ev_o(ev), .ev_prio_o(ev_prio)
  );

  // capture regs are untouched by bytes 0..15 of a following frame, so they hold for the pulse
  assign pause_valid_o = ev;
  assign is_pfc_o      = ev && ev_prio;
  assign pause_time_o  = (ev && !ev_prio) ? f16 : '0;
  assign pev_o         = (ev && ev_prio) ? f16[7:0] : '0;
  assign pfc_time_o    = (ev && ev_prio) ? times : '0;

  AST_QUIET_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pause_valid_o |-> (pause_time_o == '0 && pev_o == '0 && !is_pfc_o)) else $error("data leak"); // R9
  AST_STD_NO_PEV: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pause_valid_o && !is_pfc_o) |-> (pev_o == '0 && pfc_time_o == '0)) else $error("std fields"); // R4
endmodule

// File: tb/tb_pause_det.sv
module tb_pause_det;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic              rx_valid = 0, rx_sof = 0, rx_eof = 0, crc_err = 0;
  logic [7:0]        rx_data = 0;
  logic [15:0]       eof_len = 0;
  logic [47:0]       st_addr = 48'h02AB_CD12_3456;
  logic              fc_en = 1, uc_en = 0, pfc_en = 1, fdx = 1;
  logic              p_valid, p_pfc;
  logic [15:0]       p_time;
  logic [7:0]        p_pev;
  logic [7:0][15:0]  p_times;

  pause_det dut (
    .clk_i(clk), .rst_ni(rst_n), .rx_valid_i(rx_valid), .rx_sof_i(rx_sof),
    .rx_eof_i(rx_eof), .rx_data_i(rx_data), .eof_len_i(eof_len),
    .eof_crc_err_i(crc_err), .station_addr_i(st_addr), .rx_fc_en_i(fc_en),
    .ucast_en_i(uc_en), .pfc_en_i(pfc_en), .full_duplex_i(fdx),
    .pause_valid_o(p_valid), .is_pfc_o(p_pfc), .pause_time_o(p_time),
    .pev_o(p_pev), .pfc_time_o(p_times)
  );

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  logic [7:0] fr [0:79];
  logic [7:0][15:0] tv;

  localparam logic [47:0] MC = 48'h0180C2000001;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic build(input logic [47:0] da, input logic [15:0] et, input logic [15:0] op,
                       input logic [15:0] f16);
    for (int i = 0; i < 80; i++) fr[i] = 8'(i * 7 + 3);
    for (int i = 0; i < 6; i++) fr[i] = da[8*(5-i) +: 8];
    fr[12] = et[15:8]; fr[13] = et[7:0];
    fr[14] = op[15:8]; fr[15] = op[7:0];
    fr[16] = f16[15:8]; fr[17] = f16[7:0];
    for (int p = 0; p < 8; p++) begin
      tv[p] = 16'h1000 * 16'(p) + 16'h0A5 + 16'(p * 16'h11);
      fr[18+2*p] = tv[p][15:8]; fr[19+2*p] = tv[p][7:0];
    end
  endtask

  // drives n bytes; gap inserts one idle cycle before byte 5; leaves time at sample point
  task automatic send(input int n, input logic [15:0] len, input logic crc, input bit gap);
    for (int i = 0; i < n; i++) begin
      if (gap && i == 5) begin
        @(negedge clk); rx_valid = 0; rx_sof = 0; rx_eof = 0; rx_data = 8'hEE;
      end
      @(negedge clk);
      rx_valid = 1; rx_sof = (i == 0); rx_eof = (i == n-1); rx_data = fr[i];
      eof_len = len; crc_err = crc;
    end
    @(negedge clk);
    rx_valid = 0; rx_sof = 0; rx_eof = 0; eof_len = 0; crc_err = 0;
  endtask

  task automatic expect_none(input string tag);
    chk({tag, " valid"}, 32'(p_valid), 0);
    chk({tag, " time"}, 32'(p_time), 0);
    @(negedge clk);
  endtask

  task automatic expect_std(input string tag, input logic [15:0] t);
    chk({tag, " valid"}, 32'(p_valid), 1);
    chk({tag, " is_pfc"}, 32'(p_pfc), 0);
    chk({tag, " time"}, 32'(p_time), 32'(t));
    chk({tag, " pev"}, 32'(p_pev), 0);
    chk({tag, " ptimes"}, 32'(p_times == '0), 1);
    @(negedge clk);
    chk({tag, " pulse R9"}, 32'(p_valid), 0);
    chk({tag, " cleared R9"}, 32'(p_time), 0);
  endtask

  task automatic expect_prio(input string tag, input logic [7:0] v);
    chk({tag, " valid"}, 32'(p_valid), 1);
    chk({tag, " is_pfc"}, 32'(p_pfc), 1);
    chk({tag, " pev"}, 32'(p_pev), 32'(v));
    chk({tag, " time"}, 32'(p_time), 0);
    for (int p = 0; p < 8; p++) chk({tag, " prio time"}, 32'(p_times[p]), 32'(tv[p]));
    @(negedge clk);
    chk({tag, " pulse R9"}, 32'(p_valid), 0);
    chk({tag, " cleared R9"}, 32'(p_times == '0), 1);
  endtask

  task automatic t_reset;
    chk("R9 reset valid", 32'(p_valid), 0);
    chk("R9 reset time", 32'(p_time), 0);
    chk("R9 reset pev", 32'(p_pev), 0);
  endtask

  task automatic t_std_mcast;
    build(MC, 16'h8808, 16'h0001, 16'h1234); send(64, 16'd64, 0, 0); expect_std("R1 R4 std", 16'h1234);
  endtask

  task automatic t_prio;
    build(MC, 16'h8808, 16'h0101, 16'hFFA5); send(64, 16'd64, 0, 0); expect_prio("R5 prio", 8'hA5);
    pfc_en = 0;
    build(MC, 16'h8808, 16'h0101, 16'h00A5); send(64, 16'd64, 0, 0); expect_none("R5 prio disabled");
    pfc_en = 1;
    build(MC, 16'h8808, 16'h0002, 16'h0042); send(64, 16'd64, 0, 0); expect_none("R5 bad opcode");
  endtask

  task automatic t_da;
    build(st_addr, 16'h8808, 16'h0001, 16'h0777); send(64, 16'd64, 0, 0); expect_none("R2 ucast off");
    uc_en = 1;
    send(64, 16'd64, 0, 0); expect_std("R2 ucast on", 16'h0777);
    build(48'h0180C2000002, 16'h8808, 16'h0001, 16'h0777); send(64, 16'd64, 0, 0); expect_none("R1 bad da");
    uc_en = 0;
  endtask

  task automatic t_type;
    build(MC, 16'h8809, 16'h0001, 16'h0100); send(64, 16'd64, 0, 0); expect_none("R3 bad type");
  endtask

  task automatic t_status;
    build(MC, 16'h8808, 16'h0001, 16'h0200);
    send(64, 16'd65, 0, 0); expect_none("R6 len 65");
    send(64, 16'd64, 1, 0); expect_none("R6 crc err");
  endtask

  task automatic t_ctrl;
    build(MC, 16'h8808, 16'h0001, 16'h0300);
    fc_en = 0; send(64, 16'd64, 0, 0); expect_none("R7 fc off"); fc_en = 1;
    fdx = 0;   send(64, 16'd64, 0, 0); expect_none("R8 half duplex"); fdx = 1;
  endtask

  task automatic t_early;
    build(MC, 16'h8808, 16'h0001, 16'h0400);
    send(17, 16'd64, 0, 0); expect_none("R10 std early");
    send(18, 16'd64, 0, 0); expect_std("R10 std boundary", 16'h0400);
    build(MC, 16'h8808, 16'h0101, 16'h003C);
    send(33, 16'd64, 0, 0); expect_none("R10 prio early");
    send(34, 16'd64, 0, 0); expect_prio("R10 prio boundary", 8'h3C);
  endtask

  task automatic t_stream;
    build(MC, 16'h8808, 16'h0001, 16'h0B0B);
    send(64, 16'd64, 0, 1); expect_std("R11 gap", 16'h0B0B);
    build(48'h112233445566, 16'h0000, 16'h0000, 16'h0000);
    for (int i = 0; i < 10; i++) begin
      @(negedge clk); rx_valid = 1; rx_sof = (i == 0); rx_eof = 0; rx_data = fr[i];
    end
    build(MC, 16'h8808, 16'h0001, 16'h0C0C);
    send(64, 16'd64, 0, 0); expect_std("R11 restart", 16'h0C0C);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_std_mcast();
    t_prio();
    t_da();
    t_type();
    t_status();
    t_ctrl();
    t_early();
    t_stream();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule